// File: doc/BRIEF.md
# Channel Status and User Bit Capture

This block gathers the channel-status (C) bit and user (U) bit of every audio subframe on a two-channel digital audio link and assembles them into 192-bit blocks, one status block and one user block per channel. A subframe decoder upstream presents each decoded subframe as a one-cycle strobe. The strobe carries the channel number, the C and U bits, and a flag that marks the first frame of a block. Software or a bus bridge reads the assembled blocks through a simple registered read port. Each block is exposed as six 32-bit words.

Bits are first collected in a shadow store. The readable words change all at once when the last subframe of the 192nd frame arrives, so a read never returns a half-updated block. At that moment the new status block of each channel is compared with the one it replaces. A per-channel change event is raised when they differ, together with a shared block-end event. A block-start event is raised when collection begins. Event masking and enabling belong to the interrupt logic outside this block.

Top module: `cbu_capture`

## Requirements
- R1: After reset every event flag is low and every mapped word reads zero.
- R2: A channel-0 subframe strobe with the block-start flag set begins collection at frame 0, and event bit 11 is high for exactly the one cycle after that strobe. A block-start flag on a channel-1 subframe is not honoured.
- R3: Bit n of a block (n = 0 for the frame that carried the block-start flag) is placed in word n/32 at bit position n mod 32. Status word r of channel x is at byte address 0x30 + 0x30*x + 4*r, and user word r of channel x is at 0x48 + 0x30*x + 4*r.
- R4: The readable words keep the previous block's contents until the channel-1 subframe of frame 191 is taken. All 24 words then change in the same cycle.
- R5: Event bit 3 (block end) is high for exactly the one cycle after the closing channel-1 subframe of frame 191. It is never high together with bit 11.
- R6: At block end, event bit 8+x is set when the new status block of channel x differs in any bit from the block it replaces. A difference in user bits alone sets no change bit.
- R7: A block-start flag that arrives before a block is complete discards the partial block. Counting restarts at frame 0, and the next block end comes 192 frames after the restart.
- R8: Subframe strobes that arrive while no collection is running alter no readable word and raise no event. The same holds for strobes after a completed block and before the next block start, and for strobes before any block start.
- R9: A read with rd_en high returns the addressed word on rd_data in the following cycle. Unmapped or misaligned addresses read zero. rd_data holds its value while rd_en is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sf_valid | input | 1 | One-cycle strobe per decoded subframe |
| sf_chan | input | 1 | Channel of the subframe (0 or 1) |
| sf_cbit | input | 1 | Channel-status bit of the subframe |
| sf_ubit | input | 1 | User bit of the subframe |
| sf_bstart | input | 1 | Subframe belongs to frame 0 of a block |
| rd_en | input | 1 | Read request |
| rd_addr | input | 8 | Byte address of the word to read |
| rd_data | output | 32 | Read data, valid the cycle after rd_en |
| evt_flags | output | 15 | One-cycle event pulses: bit 3 block end, bits 8/9 status change per channel, bit 11 block start |

## Verification
Each channel is given a different, irregular bit pattern, so a swapped channel, a swapped status/user bank, a shifted bit index or a reversed byte order each shows up as a wrong word. The same block is sent twice to show that an unchanged status block raises no change flag. A third block flips only the last status bit of channel 1 and one user bit of channel 0. This shows that the final bit takes part in the comparison and that user bits do not. A partial block is followed by an early restart, with a read taken in the middle of it. Strobes are also sent outside any block and on channel 1 with the start flag set. Together these cases separate atomic update, restart alignment and the ignoring of stray subframes.

// File: rtl/cbu_pkg.sv
package cbu_pkg;
  // event vector layout; the neighbouring interrupt logic decodes these bits
  localparam int EVT_W         = 15;
  localparam int EVT_BLK_END   = 3;
  localparam int EVT_CHG_BASE  = 8;
  localparam int EVT_BLK_START = 11;

  typedef enum logic {
    ST_IDLE    = 1'b0,
    ST_COLLECT = 1'b1
  } coll_state_e;
endpackage

// File: rtl/cbu_frame_ctrl.sv
module cbu_frame_ctrl
  import cbu_pkg::*;
#(
  parameter int FRAMES = 192,
  parameter int NUM_CH = 2,
  localparam int IDX_W = $clog2(FRAMES),
  localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sf_valid,
  input  logic [CH_W-1:0]  sf_chan,
  input  logic             sf_bstart,
  output logic             wr_en,
  output logic [IDX_W-1:0] wr_idx,
  output logic             commit,
  output logic             started
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAMES - 1);
  localparam logic [CH_W-1:0]  LAST_CH  = CH_W'(NUM_CH - 1);

  coll_state_e      state_q, state_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic             start_hit, last_ch;

  assign start_hit = sf_valid && (sf_chan == '0) && sf_bstart;
  assign last_ch   = (sf_chan == LAST_CH);

  always_comb begin
    state_d = state_q;
    idx_d   = idx_q;
    wr_en   = 1'b0;
    wr_idx  = idx_q;
    commit  = 1'b0;
    started = 1'b0;
    if (start_hit) begin
      // a start always restarts counting, even in the middle of a block
      started = 1'b1;
      wr_en   = 1'b1;
      wr_idx  = '0;
      state_d = ST_COLLECT;
      idx_d   = last_ch ? IDX_W'(1) : '0;
    end else if (sf_valid && (state_q == ST_COLLECT)) begin
      wr_en = 1'b1;
      if (last_ch) begin
        if (idx_q == LAST_IDX) begin
          commit  = 1'b1;
          state_d = ST_IDLE;
        end else begin
          idx_d = idx_q + IDX_W'(1);
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
    end else if (sf_valid) begin
      state_q <= state_d;
      idx_q   <= idx_d;
    end
  end
endmodule

// File: rtl/cbu_chan_bank.sv
module cbu_chan_bank #(
  parameter int FRAMES = 192,
  localparam int IDX_W = $clog2(FRAMES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic              cbit,
  input  logic              ubit,
  input  logic              commit,
  output logic [FRAMES-1:0] vis_cs,
  output logic [FRAMES-1:0] vis_us,
  output logic              changed
);
  logic [FRAMES-1:0] cs_sh_q, cs_sh_d;
  logic [FRAMES-1:0] us_sh_q, us_sh_d;
  logic [FRAMES-1:0] cs_vis_q, us_vis_q;

  always_comb begin
    cs_sh_d = cs_sh_q;
    us_sh_d = us_sh_q;
    if (wr_en) begin
      cs_sh_d[wr_idx] = cbit;
      us_sh_d[wr_idx] = ubit;
    end
  end

  // compare includes the bit arriving in the closing cycle
  assign changed = commit && (cs_sh_d != cs_vis_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_sh_q <= '0;
      us_sh_q <= '0;
    end else if (wr_en) begin
      cs_sh_q <= cs_sh_d;
      us_sh_q <= us_sh_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_vis_q <= '0;
      us_vis_q <= '0;
    end else if (commit) begin
      cs_vis_q <= cs_sh_d;
      us_vis_q <= us_sh_d;
    end
  end

  assign vis_cs = cs_vis_q;
  assign vis_us = us_vis_q;
endmodule

// File: rtl/cbu_read_mux.sv
module cbu_read_mux #(
  parameter int NUM_CH    = 2,
  parameter int FRAMES    = 192,
  parameter int WORD_W    = 32,
  parameter int ADDR_W    = 8,
  parameter int BASE_OFS  = 'h30,
  parameter int CH_STRIDE = 'h30,
  parameter int USER_OFS  = 'h18,
  localparam int WORDS    = FRAMES / WORD_W,
  localparam int BYTES_W  = WORD_W / 8
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           rd_en,
  input  logic [ADDR_W-1:0]              rd_addr,
  input  logic [NUM_CH-1:0][FRAMES-1:0]  cs_bank,
  input  logic [NUM_CH-1:0][FRAMES-1:0]  us_bank,
  output logic [WORD_W-1:0]              rd_data
);
  logic [WORD_W-1:0] rd_q, rd_d, sel;

  always_comb begin
    sel = '0;
    for (int c = 0; c < NUM_CH; c++) begin
      for (int w = 0; w < WORDS; w++) begin
        if (rd_addr == ADDR_W'(BASE_OFS + c*CH_STRIDE + w*BYTES_W))
          sel = cs_bank[c][w*WORD_W +: WORD_W];
        if (rd_addr == ADDR_W'(BASE_OFS + c*CH_STRIDE + USER_OFS + w*BYTES_W))
          sel = us_bank[c][w*WORD_W +: WORD_W];
      end
    end
    rd_d = rd_en ? sel : rd_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_q <= '0;
    else        rd_q <= rd_d;
  end

  assign rd_data = rd_q;
endmodule

// File: rtl/cbu_capture.sv
module cbu_capture
  import cbu_pkg::*;
#(
  parameter int FRAMES    = 192,
  parameter int NUM_CH    = 2,
  parameter int WORD_W    = 32,
  parameter int ADDR_W    = 8,
  parameter int BASE_OFS  = 'h30,
  parameter int CH_STRIDE = 'h30,
  parameter int USER_OFS  = 'h18,
  localparam int IDX_W    = $clog2(FRAMES),
  localparam int CH_W     = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sf_valid,
  input  logic [CH_W-1:0]   sf_chan,
  input  logic              sf_cbit,
  input  logic              sf_ubit,
  input  logic              sf_bstart,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [WORD_W-1:0] rd_data,
  output logic [EVT_W-1:0]  evt_flags
);
  logic                          wr_en, commit, started;
  logic [IDX_W-1:0]              wr_idx;
  logic [NUM_CH-1:0]             chg;
  logic [NUM_CH-1:0][FRAMES-1:0] cs_bank, us_bank;
  logic [EVT_W-1:0]              evt_q, evt_d;

  cbu_frame_ctrl #(.FRAMES(FRAMES), .NUM_CH(NUM_CH)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .sf_valid (sf_valid),
    .sf_chan  (sf_chan),
    .sf_bstart(sf_bstart),
    .wr_en    (wr_en),
    .wr_idx   (wr_idx),
    .commit   (commit),
    .started  (started)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_bank
    cbu_chan_bank #(.FRAMES(FRAMES)) u_bank (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (wr_en && (sf_chan == CH_W'(c))),
      .wr_idx (wr_idx),
      .cbit   (sf_cbit),
      .ubit   (sf_ubit),
      .commit (commit),
      .vis_cs (cs_bank[c]),
      .vis_us (us_bank[c]),
      .changed(chg[c])
    );
  end

  cbu_read_mux #(
    .NUM_CH(NUM_CH), .FRAMES(FRAMES), .WORD_W(WORD_W), .ADDR_W(ADDR_W),
    .BASE_OFS(BASE_OFS), .CH_STRIDE(CH_STRIDE), .USER_OFS(USER_OFS)
  ) u_rd (
    .clk    (clk),
    .rst_n  (rst_n),
    .rd_en  (rd_en),
    .rd_addr(rd_addr),
    .cs_bank(cs_bank),
    .us_bank(us_bank),
    .rd_data(rd_data)
  );

  always_comb begin
    evt_d                             = '0;
    evt_d[EVT_BLK_END]                = commit;
    evt_d[EVT_BLK_START]              = started;
    evt_d[EVT_CHG_BASE +: NUM_CH]     = chg;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) evt_q <= '0;
    else        evt_q <= evt_d;
  end

  assign evt_flags = evt_q;
endmodule

// File: rtl/cbu_capture_chk.sv
module cbu_capture_chk
  import cbu_pkg::*;
#(
  parameter int FRAMES    = 192,
  parameter int NUM_CH    = 2,
  parameter int WORD_W    = 32,
  parameter int ADDR_W    = 8,
  parameter int BASE_OFS  = 'h30,
  parameter int CH_STRIDE = 'h30,
  parameter int USER_OFS  = 'h18,
  localparam int CH_W     = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int LAST_ADR = BASE_OFS + (NUM_CH-1)*CH_STRIDE + USER_OFS
                            + (FRAMES/WORD_W - 1)*(WORD_W/8)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sf_valid,
  input logic [CH_W-1:0]   sf_chan,
  input logic              sf_bstart,
  input logic              rd_en,
  input logic [ADDR_W-1:0] rd_addr,
  input logic [WORD_W-1:0] rd_data,
  input logic [EVT_W-1:0]  evt_flags
);
  // R2
  start_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sf_valid && (sf_chan == '0) && sf_bstart |=> evt_flags[EVT_BLK_START]);

  // R5
  end_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt_flags[EVT_BLK_END] |=> !evt_flags[EVT_BLK_END]);

  // R5
  start_end_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(evt_flags[EVT_BLK_END] && evt_flags[EVT_BLK_START]));

  // R6
  chg_with_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|evt_flags[EVT_CHG_BASE +: NUM_CH]) |-> evt_flags[EVT_BLK_END]);

  // R8
  no_strobe_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sf_valid |=> (evt_flags == '0));

  // R9
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rd_data));

  // R9
  unmapped_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en && (int'(rd_addr) > LAST_ADR) |=> (rd_data == '0));
endmodule

bind cbu_capture cbu_capture_chk #(
  .FRAMES(FRAMES), .NUM_CH(NUM_CH), .WORD_W(WORD_W), .ADDR_W(ADDR_W),
  .BASE_OFS(BASE_OFS), .CH_STRIDE(CH_STRIDE), .USER_OFS(USER_OFS)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .sf_valid (sf_valid),
  .sf_chan  (sf_chan),
  .sf_bstart(sf_bstart),
  .rd_en    (rd_en),
  .rd_addr  (rd_addr),
  .rd_data  (rd_data),
  .evt_flags(evt_flags)
);

// File: tb/cbu_capture_test.sv
module cbu_capture_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        sf_valid, sf_chan, sf_cbit, sf_ubit, sf_bstart;
  logic        rd_en;
  logic [7:0]  rd_addr;
  logic [31:0] rd_data;
  logic [14:0] evt_flags;

  int checks = 0;
  int fails  = 0;
  int end_cnt = 0;
  logic [14:0] last_evt;
  logic [14:0] evt_or;
  logic [191:0] exp_cs [2];
  logic [191:0] exp_us [2];

  always #4 clk = ~clk;

  cbu_capture uut (
    .clk(clk), .rst_n(rst_n), .sf_valid(sf_valid), .sf_chan(sf_chan),
    .sf_cbit(sf_cbit), .sf_ubit(sf_ubit), .sf_bstart(sf_bstart),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .evt_flags(evt_flags)
  );

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  function automatic logic [191:0] pat(input int seed);
    logic [191:0] v;
    for (int i = 0; i < 192; i++) v[i] = (((i * seed) + (i >> 3)) % 5) < 2;
    return v;
  endfunction

  function automatic logic [7:0] word_addr(input int ch, input int user, input int w);
    return 8'(8'h30 + ch * 8'h30 + user * 8'h18 + w * 4);
  endfunction

  task automatic send_sub(input logic ch, input logic c, input logic u, input logic bs);
    @(negedge clk);
    last_evt = evt_flags;
    evt_or   = evt_or | evt_flags;
    if (evt_flags[3]) end_cnt++;
    sf_valid = 1'b1; sf_chan = ch; sf_cbit = c; sf_ubit = u; sf_bstart = bs;
  endtask

  task automatic idle();
    @(negedge clk);
    last_evt = evt_flags;
    evt_or   = evt_or | evt_flags;
    if (evt_flags[3]) end_cnt++;
    sf_valid = 1'b0; sf_bstart = 1'b0;
  endtask

  task automatic send_frames(input logic [191:0] c0, input logic [191:0] u0,
                             input logic [191:0] c1, input logic [191:0] u1,
                             input int n, input bit with_start, output logic [14:0] start_evt);
    start_evt = '0;
    for (int f = 0; f < n; f++) begin
      send_sub(1'b0, c0[f], u0[f], with_start && (f == 0));
      send_sub(1'b1, c1[f], u1[f], 1'b0);
      if (f == 0) start_evt = last_evt;
    end
    idle();
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    rd_en = 1'b1; rd_addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    d = rd_data;
  endtask

  task automatic verify_all(input string req);
    logic [31:0] d;
    for (int ch = 0; ch < 2; ch++)
      for (int w = 0; w < 6; w++) begin
        rd(word_addr(ch, 0, w), d);
        check({req, " status word"}, d, exp_cs[ch][w*32 +: 32]);
        rd(word_addr(ch, 1, w), d);
        check({req, " user word"}, d, exp_us[ch][w*32 +: 32]);
      end
  endtask

  // full block with expected end event computed from the model
  task automatic full_block(input string req, input logic [191:0] c0, input logic [191:0] u0,
                            input logic [191:0] c1, input logic [191:0] u1);
    logic [14:0] st, ex;
    evt_or = '0; end_cnt = 0;
    send_frames(c0, u0, c1, u1, 192, 1'b1, st);
    ex = 15'(1 << 3);
    if (c0 != exp_cs[0]) ex[8] = 1'b1;
    if (c1 != exp_cs[1]) ex[9] = 1'b1;
    check({req, " R2 start flag"}, 32'(st), 32'(1 << 11));
    check({req, " R5/R6 end flags"}, 32'(last_evt), 32'(ex));
    check({req, " R5 one end per block"}, end_cnt, 1);
    exp_cs[0] = c0; exp_us[0] = u0; exp_cs[1] = c1; exp_us[1] = u1;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    check("R1 events after reset", 32'(evt_flags), 0);
    rd(8'h30, d); check("R1 first word", d, 0);
    rd(8'h8C, d); check("R1 last word", d, 0);
  endtask

  task automatic t_first_block();
    full_block("first", pat(3), pat(7), pat(11), pat(13));
    verify_all("R3/R4 first");
  endtask

  task automatic t_same_block();
    full_block("R6 same", pat(3), pat(7), pat(11), pat(13));
    check("R6 no change flags", 32'(last_evt[9:8]), 0);
  endtask

  task automatic t_change();
    logic [191:0] c1, u0;
    c1 = pat(11); c1[191] = ~c1[191];
    u0 = pat(7);  u0[5]   = ~u0[5];
    full_block("R6 change", pat(3), u0, c1, pat(13));
    check("R6 only channel 1 flag", 32'(last_evt[9:8]), 32'h2);
    verify_all("R6 contents");
  endtask

  task automatic t_restart();
    logic [14:0] st;
    logic [31:0] d;
    evt_or = '0; end_cnt = 0;
    send_frames(~pat(17), ~pat(19), ~pat(23), ~pat(29), 100, 1'b1, st);
    check("R4 no end mid block", end_cnt, 0);
    rd(word_addr(0, 0, 0), d); check("R4 old status during collection", d, exp_cs[0][31:0]);
    rd(word_addr(1, 1, 5), d); check("R4 old user during collection", d, exp_us[1][191:160]);
    full_block("R7 restart", pat(17), pat(19), pat(23), pat(29));
    verify_all("R7 restart contents");
  endtask

  task automatic t_ignored();
    logic [14:0] st;
    evt_or = '0;
    send_sub(1'b1, 1'b1, 1'b1, 1'b1);
    idle();
    send_frames(~pat(5), ~pat(6), ~pat(9), ~pat(10), 20, 1'b0, st);
    check("R8 no events from stray subframes", 32'(evt_or), 0);
    verify_all("R8 contents untouched");
  endtask

  task automatic t_read_port();
    logic [31:0] d, held;
    rd(8'h2C, d); check("R9 below map", d, 0);
    rd(8'h90, d); check("R9 above map", d, 0);
    rd(8'h32, d); check("R9 misaligned", d, 0);
    rd(word_addr(1, 0, 2), held);
    check("R9 read value", held, exp_cs[1][95:64]);
    @(negedge clk); rd_addr = 8'h48;
    repeat (3) @(negedge clk);
    check("R9 hold while idle", rd_data, held);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    rst_n = 1'b0;
    sf_valid = 1'b0; sf_chan = 1'b0; sf_cbit = 1'b0; sf_ubit = 1'b0; sf_bstart = 1'b0;
    rd_en = 1'b0; rd_addr = '0;
    evt_or = '0; last_evt = '0;
    for (int c = 0; c < 2; c++) begin exp_cs[c] = '0; exp_us[c] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_ignored();
    t_first_block();
    t_same_block();
    t_change();
    t_restart();
    t_ignored();
    t_read_port();
    summary();
  end
endmodule